// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the execution stage of a small 8-bit controller that uses 13-bit instruction words. Each cycle it receives the instruction word, the current accumulator value and the 8-bit operand already fetched from the register file. It works out the 8-bit result and says where that result goes: to the accumulator, or back to the addressed register. For the conditional-skip instructions it also raises a skip request that the sequencer acts on.

The zero (Z), carry (C) and half-carry (DC) flags are held inside the block. An execute strobe commits them on the rising clock edge. Each instruction class updates its own subset of the flags. Rotates read the stored carry as their carry-in.

Result, write enables and skip are combinational and are qualified by the strobe. The register file, program counter and call stack sit outside the block. All pins are plain control and data pins: the block has no stream interface and applies no back-pressure.

Top module: `acc_alu_exec`

## Requirements
- R1: Register-operand instructions have instr[12:11]=00 and a 4-bit operation code in instr[10:7]. instr[6] picks the destination: 0 asserts wr_acc, 1 asserts wr_reg. The two are never asserted together. Codes: 0 move accumulator to register (only with instr[6]=1; with instr[6]=0 nothing is written), 1 clear, 2 subtract, 3 decrement, 4 OR, 5 AND, 6 XOR, 7 add, 8 move, 9 complement, 10 increment, 11 decrement-skip, 12 rotate right, 13 rotate left, 14 nibble swap, 15 increment-skip.
- R2: Add forms give acc+operand. C is the carry out of bit 7, DC is the carry out of bit 3, and Z is set when the result is 0.
- R3: Subtract forms give operand-acc, where the operand is the register or the literal. C=1 means no borrow, DC=1 means no borrow out of the low nibble, and Z is set when the result is 0.
- R4: OR, AND, XOR, complement, increment, decrement and register move update only Z, from result==0. C and DC are kept.
- R5: Move-accumulator-to-register writes acc into the register and leaves all flags unchanged. Clear (codes 1) writes 0 and sets Z, leaving C and DC unchanged.
- R6: Decrement-skip and increment-skip write operand-1 or operand+1. They assert skip when that result is 0 and change no flag.
- R7: Rotate right gives {C, operand[7:1]} and loads operand[0] into C. Rotate left gives {operand[6:0], C} and loads operand[7] into C. Z and DC are kept.
- R8: Nibble swap gives {operand[3:0], operand[7:4]} and changes no flag.
- R9: Bit instructions have instr[12:11]=01, a sub-code in instr[10:9] and a bit index in instr[8:6]. Sub-code 00 clears the bit and 01 sets it, both writing the register. 10 skips when the bit is 0 and 11 skips when it is 1; neither writes anything. No bit instruction changes a flag.
- R10: Literal instructions have instr[12:11]=11, a sub-code in instr[10:8] and the literal k in instr[7:0], and always write the accumulator. Sub-codes 000 and 100 load k with no flag change. 001, 010 and 011 give OR, AND and XOR with k and update only Z. 101 gives k-acc and 111 gives k+acc.
- R11: Flags change only at a rising edge with exec_en=1. While exec_en=0 the outputs wr_acc, wr_reg and skip are 0 and the flags hold. Reset (rst_n low) clears all three flags.
- R12: Encodings outside the ALU classes write nothing, raise no skip and keep the flags. These are instr[12:11]=10 and literal sub-code 110.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| exec_en | input | 1 | Execute strobe; qualifies writes, skip and flag update |
| instr | input | 13 | Instruction word |
| acc_in | input | 8 | Current accumulator value |
| reg_in | input | 8 | Register operand fetched by the register file |
| result | output | 8 | Computed result |
| wr_acc | output | 1 | Write result into the accumulator |
| wr_reg | output | 1 | Write result back to the addressed register |
| skip | output | 1 | Skip the next instruction |
| flag_z | output | 1 | Stored zero flag |
| flag_c | output | 1 | Stored carry / not-borrow flag |
| flag_dc | output | 1 | Stored half-carry / not-half-borrow flag |

## Verification
Result, wr_acc, wr_reg and skip are due in the same cycle as the instruction. The bench drives inputs on the falling edge and samples these outputs one nanosecond later. Flags are due one rising edge after a cycle with exec_en high, so the bench samples them one nanosecond after that edge. Before each table vector, a preceding literal add puts the flags in a known all-zero or all-one state, so that each check can tell kept flags from written ones.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned ALU_W   = 8;
  localparam int unsigned NIB_W   = ALU_W / 2;
  localparam int unsigned BIT_W   = $clog2(ALU_W);
  localparam int unsigned INSTR_W = 13;

  typedef enum logic [4:0] {
    OP_NONE, OP_MOVRA, OP_CLR, OP_SUB, OP_DEC, OP_OR, OP_AND, OP_XOR,
    OP_ADD, OP_MOV, OP_COM, OP_INC, OP_DJZ, OP_RRC, OP_RLC, OP_SWAP,
    OP_JZ, OP_BCLR, OP_BSET, OP_BTC, OP_BTS, OP_LDK
  } alu_op_e;

  typedef struct packed {
    alu_op_e          op;
    logic             to_reg;
    logic             use_k;
    logic [BIT_W-1:0] bit_idx;
    logic [ALU_W-1:0] k;
  } alu_dec_t;
endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import alu_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output alu_dec_t           dec
);
  logic unused_addr;
  assign unused_addr = ^instr[5:0];

  always_comb begin
    dec         = '0;
    dec.op      = OP_NONE;
    dec.k       = instr[ALU_W-1:0];
    dec.bit_idx = instr[8:6];
    dec.to_reg  = instr[6];
    if (!instr[12]) begin
      if (instr[11]) begin
        unique case (instr[10:9])
          2'b00:   dec.op = OP_BCLR;
          2'b01:   dec.op = OP_BSET;
          2'b10:   dec.op = OP_BTC;
          default: dec.op = OP_BTS;
        endcase
      end else begin
        unique case (instr[10:7])
          4'd0:    dec.op = instr[6] ? OP_MOVRA : OP_NONE;
          4'd1:    dec.op = OP_CLR;
          4'd2:    dec.op = OP_SUB;
          4'd3:    dec.op = OP_DEC;
          4'd4:    dec.op = OP_OR;
          4'd5:    dec.op = OP_AND;
          4'd6:    dec.op = OP_XOR;
          4'd7:    dec.op = OP_ADD;
          4'd8:    dec.op = OP_MOV;
          4'd9:    dec.op = OP_COM;
          4'd10:   dec.op = OP_INC;
          4'd11:   dec.op = OP_DJZ;
          4'd12:   dec.op = OP_RRC;
          4'd13:   dec.op = OP_RLC;
          4'd14:   dec.op = OP_SWAP;
          default: dec.op = OP_JZ;
        endcase
      end
    end else if (instr[11]) begin
      dec.use_k  = 1'b1;
      dec.to_reg = 1'b0;
      unique case (instr[10:8])
        3'b000, 3'b100: dec.op = OP_LDK;
        3'b001:         dec.op = OP_OR;
        3'b010:         dec.op = OP_AND;
        3'b011:         dec.op = OP_XOR;
        3'b101:         dec.op = OP_SUB;
        3'b111:         dec.op = OP_ADD;
        default:        dec.op = OP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
(
  input  alu_dec_t         dec,
  input  logic [ALU_W-1:0] acc,
  input  logic [ALU_W-1:0] regv,
  input  logic             c_in,
  output logic [ALU_W-1:0] res,
  output logic             wr_a,
  output logic             wr_r,
  output logic             skip,
  output logic [2:0]       upd,     // {z, c, dc}
  output logic [2:0]       nflags   // {z, c, dc}
);
  logic [ALU_W-1:0] opb;
  logic [ALU_W:0]   sum, dif;
  logic [NIB_W:0]   hsum, hdif;
  logic [ALU_W-1:0] onehot;
  logic             n_c, n_dc, writes;

  assign opb  = dec.use_k ? dec.k : regv;
  assign sum  = {1'b0, acc} + {1'b0, opb};
  assign dif  = {1'b0, opb} - {1'b0, acc};
  assign hsum = {1'b0, acc[NIB_W-1:0]} + {1'b0, opb[NIB_W-1:0]};
  assign hdif = {1'b0, opb[NIB_W-1:0]} - {1'b0, acc[NIB_W-1:0]};

  for (genvar g = 0; g < ALU_W; g++) begin : g_mask
    assign onehot[g] = (dec.bit_idx == BIT_W'(g));
  end

  always_comb begin
    res    = '0;
    writes = 1'b1;
    skip   = 1'b0;
    upd    = 3'b000;
    n_c    = c_in;
    n_dc   = 1'b0;
    wr_a   = 1'b0;
    wr_r   = 1'b0;
    unique case (dec.op)
      OP_MOVRA: res = acc;
      OP_CLR:   begin res = '0; upd = 3'b100; end
      OP_SUB:   begin res = dif[ALU_W-1:0]; n_c = ~dif[ALU_W]; n_dc = ~hdif[NIB_W]; upd = 3'b111; end
      OP_ADD:   begin res = sum[ALU_W-1:0]; n_c = sum[ALU_W]; n_dc = hsum[NIB_W]; upd = 3'b111; end
      OP_DEC:   begin res = regv - ALU_W'(1); upd = 3'b100; end
      OP_INC:   begin res = regv + ALU_W'(1); upd = 3'b100; end
      OP_OR:    begin res = acc | opb; upd = 3'b100; end
      OP_AND:   begin res = acc & opb; upd = 3'b100; end
      OP_XOR:   begin res = acc ^ opb; upd = 3'b100; end
      OP_MOV:   begin res = regv; upd = 3'b100; end
      OP_COM:   begin res = ~regv; upd = 3'b100; end
      OP_DJZ:   begin res = regv - ALU_W'(1); skip = (res == '0); end
      OP_JZ:    begin res = regv + ALU_W'(1); skip = (res == '0); end
      OP_RRC:   begin res = {c_in, regv[ALU_W-1:1]}; n_c = regv[0]; upd = 3'b010; end
      OP_RLC:   begin res = {regv[ALU_W-2:0], c_in}; n_c = regv[ALU_W-1]; upd = 3'b010; end
      OP_SWAP:  res = {regv[NIB_W-1:0], regv[ALU_W-1:NIB_W]};
      OP_BCLR:  res = regv & ~onehot;
      OP_BSET:  res = regv | onehot;
      OP_BTC:   begin writes = 1'b0; skip = ~|(regv & onehot); end
      OP_BTS:   begin writes = 1'b0; skip = |(regv & onehot); end
      OP_LDK:   res = dec.k;
      default:  writes = 1'b0;
    endcase
    if (writes) begin
      if (dec.op == OP_BCLR || dec.op == OP_BSET) wr_r = 1'b1;
      else begin
        wr_r = dec.to_reg;
        wr_a = ~dec.to_reg;
      end
    end
  end

  assign nflags = {(res == '0), n_c, n_dc};
endmodule

// File: rtl/alu_flags.sv
module alu_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [2:0] upd,
  input  logic [2:0] nflags,
  output logic [2:0] flags
);
  for (genvar g = 0; g < 3; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              flags[g] <= 1'b0;
      else if (en && upd[g])   flags[g] <= nflags[g];
    end
  end
endmodule

// File: rtl/acc_alu_exec.sv
module acc_alu_exec
  import alu_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exec_en,
  input  logic [INSTR_W-1:0] instr,
  input  logic [ALU_W-1:0]   acc_in,
  input  logic [ALU_W-1:0]   reg_in,
  output logic [ALU_W-1:0]   result,
  output logic               wr_acc,
  output logic               wr_reg,
  output logic               skip,
  output logic               flag_z,
  output logic               flag_c,
  output logic               flag_dc
);
  alu_dec_t   dec;
  logic       wa, wr, sk;
  logic [2:0] upd, nflags, flags;

  alu_decode u_dec (.instr(instr), .dec(dec));

  alu_core u_core (
    .dec(dec), .acc(acc_in), .regv(reg_in), .c_in(flags[1]),
    .res(result), .wr_a(wa), .wr_r(wr), .skip(sk),
    .upd(upd), .nflags(nflags)
  );

  alu_flags u_flags (
    .clk(clk), .rst_n(rst_n), .en(exec_en),
    .upd(upd), .nflags(nflags), .flags(flags)
  );

  assign wr_acc  = wa & exec_en;
  assign wr_reg  = wr & exec_en;
  assign skip    = sk & exec_en;
  assign flag_z  = flags[2];
  assign flag_c  = flags[1];
  assign flag_dc = flags[0];
endmodule

// File: rtl/acc_alu_exec_chk.sv
module acc_alu_exec_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        exec_en,
  input logic [12:0] instr,
  input logic [7:0]  result,
  input logic        wr_acc,
  input logic        wr_reg,
  input logic        skip,
  input logic        flag_z,
  input logic        flag_c,
  input logic        flag_dc
);
  logic       is_reg, is_bit, is_far;
  logic [3:0] rop;
  assign is_reg = (instr[12:11] == 2'b00);
  assign is_bit = (instr[12:11] == 2'b01);
  assign is_far = (instr[12:11] == 2'b10);
  assign rop    = instr[10:7];

  p_dest_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_acc && wr_reg));
  p_dest_sel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && is_reg && rop != 4'd0 |-> (wr_acc == !instr[6]) && (wr_reg == instr[6]));
  p_logic_z_r4: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && is_reg && (rop == 4'd4 || rop == 4'd5 || rop == 4'd6)
    |=> flag_z == $past(result == 8'h00) && $stable({flag_c, flag_dc}));
  p_skip_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && is_reg && (rop == 4'd11 || rop == 4'd15) |=> $stable({flag_z, flag_c, flag_dc}));
  p_rot_only_c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && is_reg && (rop == 4'd12 || rop == 4'd13) |=> $stable({flag_z, flag_dc}));
  p_swap_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && is_reg && rop == 4'd14 |=> $stable({flag_z, flag_c, flag_dc}));
  p_test_nowrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && is_bit && instr[10] |-> !wr_acc && !wr_reg);
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_en |-> !wr_acc && !wr_reg && !skip);
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_en |=> $stable({flag_z, flag_c, flag_dc}));
  p_far_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && is_far |-> !wr_acc && !wr_reg && !skip);
endmodule

bind acc_alu_exec acc_alu_exec_chk i_chk (
  .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .instr(instr),
  .result(result), .wr_acc(wr_acc), .wr_reg(wr_reg), .skip(skip),
  .flag_z(flag_z), .flag_c(flag_c), .flag_dc(flag_dc)
);

// File: tb/test_acc_alu_exec.sv
module test_acc_alu_exec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exec_en = 1'b0;
  logic [12:0] instr = '0;
  logic [7:0]  acc_in = '0, reg_in = '0;
  logic [7:0]  result;
  logic        wr_acc, wr_reg, skip, flag_z, flag_c, flag_dc;

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  acc_alu_exec i_acc_alu_exec (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .instr(instr),
    .acc_in(acc_in), .reg_in(reg_in), .result(result),
    .wr_acc(wr_acc), .wr_reg(wr_reg), .skip(skip),
    .flag_z(flag_z), .flag_c(flag_c), .flag_dc(flag_dc)
  );

  function automatic logic [12:0] rop(input logic [3:0] op, input logic d);
    return {2'b00, op, d, 6'd5};
  endfunction
  function automatic logic [12:0] bop(input logic [1:0] sel, input logic [2:0] b);
    return {2'b01, sel, b, 6'd5};
  endfunction
  function automatic logic [12:0] lop(input logic [2:0] sel, input logic [7:0] k);
    return {2'b11, sel, k};
  endfunction

  // {req, instr, acc, reg, preset, exp_res, wa, wr, skip, {z,c,dc}}
  localparam int NV = 26;
  localparam logic [47:0] VECS [0:NV-1] = '{
    {4'd2,  rop(4'd7, 1'b0), 8'h38, 8'h48, 1'b0, 8'h80, 3'b100, 3'b001}, // R2
    {4'd2,  rop(4'd7, 1'b1), 8'hFF, 8'h01, 1'b0, 8'h00, 3'b010, 3'b111}, // R2
    {4'd3,  rop(4'd2, 1'b0), 8'h01, 8'h10, 1'b0, 8'h0F, 3'b100, 3'b010}, // R3
    {4'd3,  rop(4'd2, 1'b1), 8'h05, 8'h05, 1'b0, 8'h00, 3'b010, 3'b111}, // R3
    {4'd3,  rop(4'd2, 1'b0), 8'h01, 8'h00, 1'b1, 8'hFF, 3'b100, 3'b000}, // R3
    {4'd4,  rop(4'd5, 1'b0), 8'hF0, 8'h0F, 1'b0, 8'h00, 3'b100, 3'b100}, // R4
    {4'd4,  rop(4'd10,1'b1), 8'h00, 8'hFF, 1'b0, 8'h00, 3'b010, 3'b100}, // R4
    {4'd4,  rop(4'd3, 1'b0), 8'h00, 8'h00, 1'b1, 8'hFF, 3'b100, 3'b011}, // R4
    {4'd6,  rop(4'd11,1'b1), 8'h00, 8'h01, 1'b0, 8'h00, 3'b011, 3'b000}, // R6
    {4'd6,  rop(4'd15,1'b0), 8'h00, 8'h7F, 1'b1, 8'h80, 3'b100, 3'b111}, // R6
    {4'd7,  rop(4'd12,1'b1), 8'h00, 8'h02, 1'b1, 8'h81, 3'b010, 3'b101}, // R7
    {4'd7,  rop(4'd13,1'b0), 8'h00, 8'h80, 1'b0, 8'h00, 3'b100, 3'b010}, // R7
    {4'd8,  rop(4'd14,1'b1), 8'h00, 8'hA5, 1'b0, 8'h5A, 3'b010, 3'b000}, // R8
    {4'd4,  rop(4'd9, 1'b0), 8'h00, 8'hFF, 1'b1, 8'h00, 3'b100, 3'b111}, // R4
    {4'd5,  rop(4'd0, 1'b1), 8'h00, 8'h77, 1'b0, 8'h00, 3'b010, 3'b000}, // R5
    {4'd5,  rop(4'd1, 1'b0), 8'h55, 8'h00, 1'b0, 8'h00, 3'b100, 3'b100}, // R5
    {4'd9,  bop(2'd1, 3'd7), 8'h00, 8'h00, 1'b0, 8'h80, 3'b010, 3'b000}, // R9
    {4'd9,  bop(2'd0, 3'd0), 8'h00, 8'hFF, 1'b1, 8'hFE, 3'b010, 3'b111}, // R9
    {4'd9,  bop(2'd2, 3'd3), 8'h00, 8'hF7, 1'b0, 8'h00, 3'b001, 3'b000}, // R9
    {4'd9,  bop(2'd3, 3'd3), 8'h00, 8'hF7, 1'b0, 8'h00, 3'b000, 3'b000}, // R9
    {4'd10, lop(3'd5, 8'h20), 8'h21, 8'h00, 1'b0, 8'hFF, 3'b100, 3'b000}, // R10
    {4'd10, lop(3'd7, 8'h0F), 8'h01, 8'h00, 1'b0, 8'h10, 3'b100, 3'b001}, // R10
    {4'd10, lop(3'd4, 8'h00), 8'h33, 8'h00, 1'b0, 8'h00, 3'b100, 3'b000}, // R10
    {4'd10, lop(3'd3, 8'hAA), 8'hAA, 8'h00, 1'b1, 8'h00, 3'b100, 3'b111}, // R10
    {4'd12, 13'h1123,        8'h00, 8'h00, 1'b0, 8'h00, 3'b000, 3'b000}, // R12
    {4'd12, lop(3'd6, 8'h85), 8'h00, 8'h00, 1'b1, 8'h00, 3'b000, 3'b111}  // R12
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [12:0] i, input logic [7:0] a, input logic [7:0] r, input logic en);
    @(negedge clk);
    instr = i; acc_in = a; reg_in = r; exec_en = en;
    #1;
  endtask

  task automatic preset(input logic ones);
    drive(lop(3'd7, ones ? 8'hFF : 8'h01), 8'h01, 8'h00, 1'b1);
  endtask

  task automatic flags_after_edge(input string req, input logic [2:0] exp);
    @(posedge clk); #1;
    check({flag_z, flag_c, flag_dc} == exp, req, {flag_z, flag_c, flag_dc}, exp);
  endtask

  // independent reference model
  logic m_z, m_c, m_dc;
  task automatic model(input logic [12:0] i, input logic [7:0] a, input logic [7:0] r,
                       output logic [7:0] res, output logic wa, output logic wr, output logic sk);
    int ia = a, ir = r, t;
    logic zu = 1'b0;
    res = 8'h00; wa = 1'b0; wr = 1'b0; sk = 1'b0;
    if (i[12:11] == 2'b00) begin
      case (i[10:7])
        4'd0:  res = a;
        4'd1:  begin res = 0; zu = 1; end
        4'd2:  begin t = ir - ia; res = t[7:0]; m_c = (ir >= ia); m_dc = ((ir % 16) >= (ia % 16)); zu = 1; end
        4'd3:  begin res = r - 8'd1; zu = 1; end
        4'd4:  begin res = a | r; zu = 1; end
        4'd5:  begin res = a & r; zu = 1; end
        4'd6:  begin res = a ^ r; zu = 1; end
        4'd7:  begin t = ia + ir; res = t[7:0]; m_c = (t > 255); m_dc = ((ia % 16) + (ir % 16) > 15); zu = 1; end
        4'd8:  begin res = r; zu = 1; end
        4'd9:  begin res = ~r; zu = 1; end
        4'd10: begin res = r + 8'd1; zu = 1; end
        4'd11: begin res = r - 8'd1; sk = (r == 8'd1); end
        4'd12: begin res = (r >> 1) | {m_c, 7'd0}; m_c = r[0]; end
        4'd13: begin res = (r << 1) | {7'd0, m_c}; m_c = r[7]; end
        4'd14: res = {r[3:0], r[7:4]};
        default: begin res = r + 8'd1; sk = (r == 8'hFF); end
      endcase
      if (i[10:7] != 4'd0 || i[6]) begin wa = !i[6]; wr = i[6]; end
    end else if (i[12:11] == 2'b01) begin
      case (i[10:9])
        2'd0: begin res = r & ~(8'd1 << i[8:6]); wr = 1; end
        2'd1: begin res = r | (8'd1 << i[8:6]); wr = 1; end
        2'd2: sk = !r[i[8:6]];
        default: sk = r[i[8:6]];
      endcase
    end else if (i[12:11] == 2'b11) begin
      wa = 1;
      case (i[10:8])
        3'd1: begin res = a | i[7:0]; zu = 1; end
        3'd2: begin res = a & i[7:0]; zu = 1; end
        3'd3: begin res = a ^ i[7:0]; zu = 1; end
        3'd5: begin t = int'(i[7:0]) - ia; res = t[7:0]; m_c = (int'(i[7:0]) >= ia);
                    m_dc = ((i[3:0]) >= a[3:0]); zu = 1; end
        3'd7: begin t = int'(i[7:0]) + ia; res = t[7:0]; m_c = (t > 255);
                    m_dc = ({1'b0, i[3:0]} + {1'b0, a[3:0]} > 5'd15); zu = 1; end
        3'd6: wa = 0;
        default: res = i[7:0];
      endcase
    end
    if (zu) m_z = (res == 8'h00);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] e_res;
    logic e_wa, e_wr, e_sk;
    // reset state, R11
    repeat (3) @(posedge clk);
    #1;
    check({flag_z, flag_c, flag_dc} == 3'b000, "R11 reset flags", {flag_z, flag_c, flag_dc}, 0);
    check(!wr_acc && !wr_reg && !skip, "R11 reset idle", {wr_acc, wr_reg, skip}, 0);
    rst_n = 1'b1;

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic [47:0] e = VECS[v];
      string tag = $sformatf("R%0d vec%0d", e[47:44], v);
      preset(e[14]);
      drive(e[43:31], e[30:23], e[22:15], 1'b1);
      if (e[5] || e[4])
        check(result == e[13:6], {tag, " result"}, result, e[13:6]);
      check({wr_acc, wr_reg, skip} == e[5:3], {tag, " wa/wr/skip"}, {wr_acc, wr_reg, skip}, e[5:3]);
      flags_after_edge({tag, " flags"}, e[2:0]);
    end

    // R11: strobe low suppresses writes, skip and flag update
    preset(1'b1);
    drive(lop(3'd7, 8'h01), 8'h01, 8'h00, 1'b0);
    check(!wr_acc && !wr_reg && !skip, "R11 idle outputs", {wr_acc, wr_reg, skip}, 0);
    flags_after_edge("R11 idle hold", 3'b111);
    drive(rop(4'd11, 1'b1), 8'h00, 8'h01, 1'b0);
    check(!skip && !wr_reg, "R11 idle skip", {wr_reg, skip}, 0);

    // R7: rotate uses stored carry as carry-in, chain of two rotates
    preset(1'b1);
    drive(rop(4'd13, 1'b0), 8'h00, 8'h00, 1'b1);
    check(result == 8'h01, "R7 rlc carry-in", result, 8'h01);
    flags_after_edge("R7 rlc clears C", 3'b101);
    drive(rop(4'd12, 1'b0), 8'h00, 8'h01, 1'b1);
    check(result == 8'h00, "R7 rrc carry-in zero", result, 8'h00);
    flags_after_edge("R7 rrc sets C", 3'b111);

    // R11: asynchronous reset in mid-run clears flags
    preset(1'b1);
    @(posedge clk); #1;
    rst_n = 1'b0;
    #1;
    check({flag_z, flag_c, flag_dc} == 3'b000, "R11 mid reset", {flag_z, flag_c, flag_dc}, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // random sweep against model, covers R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 R12
    preset(1'b0);
    m_z = 0; m_c = 0; m_dc = 0;
    for (int n = 0; n < 300; n++) begin
      logic [12:0] ri = 13'($urandom);
      logic [7:0]  ra = 8'($urandom), rr = 8'($urandom);
      model(ri, ra, rr, e_res, e_wa, e_wr, e_sk);
      drive(ri, ra, rr, 1'b1);
      if (e_wa || e_wr)
        check(result == e_res, "R1 random result", result, e_res);
      check({wr_acc, wr_reg, skip} == {e_wa, e_wr, e_sk}, "R1 random wa/wr/skip",
            {wr_acc, wr_reg, skip}, {e_wa, e_wr, e_sk});
      flags_after_edge("R2 random flags", {m_z, m_c, m_dc});
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule